// File: doc/BRIEF.md
# Embedded Program/Erase Status Reporter

This block models the part of a byte-wide flash array that runs a program or erase on its own and answers reads while that operation is in progress. A command decoder hands it a single accepted command, either a byte program (address plus data) or a whole-array erase. An internal cycle counter then holds the block busy for a fixed, parameterised number of clocks in place of the real cell timing. When the count ends, the result is written into a behavioural byte array.

While the block is busy, a read does not return array contents. It returns a status byte that host software can poll. Bit 7 holds the inverted value of the bit the operation will leave behind. Bit 6 flips on every read. Once the operation is done, reads return the stored bytes again.

Commands and reads both use valid/ready handshakes. A command is refused (ready low) for as long as the block is busy. The read path has a one-entry response register: a new read request is taken only when that register is empty or is being drained in the same cycle. A held response keeps its data stable. The chip-enable and output-enable pins only decide the output-enable flag that a pad ring would use to drive or float the data pins.

Top module: `pe_status_reporter`

## Requirements
- R1: After reset, busy is 0, cmd_ready is 1, rsp_valid is 0, and every byte of the array reads as all ones (the erased value).
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1, and cmd_ready equals the inverse of busy. A command offered while busy is ignored and leaves the array unchanged.
- R3: After a program command (cmd_op = 0) is accepted, busy is 1 for exactly PROG_CYCLES clock cycles. After an erase command (cmd_op = 1) is accepted, busy is 1 for exactly ERASE_CYCLES clock cycles.
- R4: When a program completes, the addressed byte becomes its old value ANDed with the command data, so bits can only be cleared.
- R5: When an erase completes, every byte of the array becomes all ones.
- R6: A read accepted while a program is busy, at any address, returns a status byte: bit 7 is the inverse of bit 7 of the data being programmed, bit 6 is the toggle bit, and bits 5..0 are 0.
- R7: A read accepted while an erase is busy returns a status byte: bit 7 is 0, bit 6 is the toggle bit, and bits 5..0 are 0.
- R8: The toggle bit is 0 on the first busy read after each command is accepted. It inverts on every later read accepted during the same operation.
- R9: A read accepted while not busy returns the stored byte. A read accepted on the very edge where busy falls still returns status.
- R10: rd_req_ready is 1 when rsp_valid is 0 or rsp_ready is 1. The response appears with rsp_valid one cycle after the request is accepted. While rsp_valid is 1 and rsp_ready is 0, rsp_valid and rsp_data hold.
- R11: out_en is 1 exactly when both ce_n and oe_n are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (not busy) |
| cmd_op | input | 1 | 0 = byte program, 1 = array erase |
| cmd_addr | input | ADDR_W | Program address |
| cmd_data | input | DATA_W | Program data |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request can be accepted |
| rd_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Stored byte or status byte |
| busy | output | 1 | Embedded operation in progress |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| out_en | output | 1 | Data pins driven when 1, floating when 0 |

## Verification
The checker relies on the consumer following the handshakes: rsp_ready may be held low for any number of cycles, and a request counts only when valid meets ready. The checker counts busy cycles itself and pairs each polled response with the toggle value from the previous one, so it expects reads to be the only thing that advances the toggle. The bench drives every input on the falling edge, lowers cmd_valid before busy can fall when it offers a command during an operation, and offers reads only at the array depth the defaults give.

// File: rtl/pesr_pkg.sv
package pesr_pkg;

  // Kind of embedded operation held by the reporter.
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } pe_op_e;

  // Latched description of the operation in flight.
  typedef struct packed {
    pe_op_e op;
    logic   msb;   // bit 7 of the data being programmed
  } op_ctx_t;

endpackage

// File: rtl/pesr_op_timer.sv
module pesr_op_timer
  import pesr_pkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  pe_op_e start_op,
  output logic   busy,
  output pe_op_e cur_op,
  output logic   done
);

  localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] remain_q;
  logic             busy_q;
  pe_op_e           op_q;

  // The final busy cycle is the one where the remaining count is zero.
  assign done   = busy_q && (remain_q == '0);
  assign busy   = busy_q;
  assign cur_op = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      op_q     <= OP_PROG;
    end else if (start && !busy_q) begin
      busy_q   <= 1'b1;
      op_q     <= start_op;
      remain_q <= (start_op == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
    end else if (done) begin
      busy_q   <= 1'b0;
    end else if (busy_q) begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/pesr_poll_status.sv
module pesr_poll_status
  import pesr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              poll,
  input  op_ctx_t           ctx,
  output logic [DATA_W-1:0] status
);

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  logic toggle_q;

  // Toggle restarts at 0 with each operation and flips per polled read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle_q <= 1'b0;
    end else if (start) begin
      toggle_q <= 1'b0;
    end else if (poll) begin
      toggle_q <= ~toggle_q;
    end
  end

  always_comb begin
    status = '0;
    status[POLL_BIT] = (ctx.op == OP_PROG) ? ~ctx.msb : 1'b0;
    status[TOG_BIT]  = toggle_q;
  end

endmodule

// File: rtl/pesr_byte_array.sv
module pesr_byte_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_prog,
  input  logic              commit_erase,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // One storage row per address; erase sets all ones, program only clears.
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[g] <= '1;
      end else if (commit_erase) begin
        cells[g] <= '1;
      end else if (commit_prog && (waddr == ADDR_W'(g))) begin
        cells[g] <= cells[g] & wdata;
      end
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/pe_status_reporter.sv
module pe_status_reporter
  import pesr_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic              out_en
);

  logic              cmd_fire;
  logic              rd_fire;
  logic              poll_fire;
  logic              op_done;
  pe_op_e            cur_op;
  op_ctx_t           ctx;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] status_byte;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign cmd_ready    = !busy;
  assign cmd_fire     = cmd_valid && cmd_ready;
  assign rd_req_ready = !rsp_valid_q || rsp_ready;
  assign rd_fire      = rd_req_valid && rd_req_ready;
  assign poll_fire    = rd_fire && busy;
  assign out_en       = !ce_n && !oe_n;

  // Program target held for the whole busy window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '1;
    end else if (cmd_fire) begin
      wr_addr_q <= cmd_addr;
      wr_data_q <= cmd_data;
    end
  end

  pesr_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cmd_fire),
    .start_op(pe_op_e'(cmd_op)),
    .busy    (busy),
    .cur_op  (cur_op),
    .done    (op_done)
  );

  assign ctx.op  = cur_op;
  assign ctx.msb = wr_data_q[DATA_W-1];

  pesr_poll_status #(
    .DATA_W(DATA_W)
  ) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cmd_fire),
    .poll  (poll_fire),
    .ctx   (ctx),
    .status(status_byte)
  );

  pesr_byte_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_prog (op_done && (cur_op == OP_PROG)),
    .commit_erase(op_done && (cur_op == OP_ERASE)),
    .waddr       (wr_addr_q),
    .wdata       (wr_data_q),
    .raddr       (rd_addr),
    .rdata       (arr_rdata)
  );

  // One-entry response register: status while busy, stored byte otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_fire) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= busy ? status_byte : arr_rdata;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/pesr_checker.sv
module pesr_checker #(
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_op,
  input logic [DATA_W-1:0] cmd_data,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              busy,
  input logic              ce_n,
  input logic              oe_n,
  input logic              out_en
);

  localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 2);

  logic             acc;
  logic             rd_acc;
  logic [CNT_W-1:0] run_len;
  logic             last_op;
  logic             last_msb;
  logic             poll_rsp;
  logic             have_prev;
  logic             prev_tog;

  assign acc    = cmd_valid && cmd_ready;
  assign rd_acc = rd_req_valid && rd_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      last_op   <= 1'b0;
      last_msb  <= 1'b0;
      poll_rsp  <= 1'b0;
      have_prev <= 1'b0;
      prev_tog  <= 1'b0;
    end else begin
      run_len  <= busy ? run_len + 1'b1 : '0;
      poll_rsp <= rd_acc && busy;
      if (acc) begin
        last_op  <= cmd_op;
        last_msb <= cmd_data[DATA_W-1];
      end
      if (acc) begin
        have_prev <= 1'b0;
      end else if (poll_rsp) begin
        have_prev <= 1'b1;
        prev_tog  <= rsp_data[6];
      end
    end
  end

  // R2: an accepted command starts the busy window
  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  // R2: nothing is accepted while busy
  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R3: busy length matches the operation kind
  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |->
      (run_len == (last_op ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES))));

  // R3: busy never outlasts the longest operation
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < CNT_W'(MAX_CYCLES)));

  // R6: polled program status inverts bit 7 and zeroes bits 5..0
  a_r6_prog_status: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rsp && !last_op) |->
      ((rsp_data[7] == !last_msb) && (rsp_data[5:0] == '0)));

  // R7: polled erase status has bit 7 low
  a_r7_erase_status: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rsp && last_op) |-> ((rsp_data[7] == 1'b0) && (rsp_data[5:0] == '0)));

  // R8: first poll reads toggle 0
  a_r8_toggle_first: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rsp && !have_prev) |-> (rsp_data[6] == 1'b0));

  // R8: later polls alternate
  a_r8_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rsp && have_prev) |-> (rsp_data[6] != prev_tog));

  // R10: a held response stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10: accepted read gives a response next cycle
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  // R11: pins float whenever either enable is high
  a_r11_float: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !out_en);

endmodule

bind pe_status_reporter pesr_checker #(
  .DATA_W      (DATA_W),
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .cmd_data    (cmd_data),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .busy        (busy),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .out_en      (out_en)
);

// File: tb/pe_status_reporter_test.sv
module pe_status_reporter_test;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int PROG_CYCLES  = 8;
  localparam int ERASE_CYCLES = 40;
  localparam int NVEC = 6;
  // Each entry: {addr, program data, expected byte afterwards}.
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1,  8'hA5, 8'hA5},
    {8'd1,  8'h3C, 8'h24},
    {8'd2,  8'hF0, 8'hF0},
    {8'd63, 8'h81, 8'h81},
    {8'd2,  8'h0F, 8'h00},
    {8'd0,  8'hFF, 8'hFF}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0, cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic rd_req_valid = 0, rsp_ready = 1, ce_n = 1, oe_n = 1;
  logic cmd_ready, rd_req_ready, rsp_valid, busy, out_en;
  logic [DATA_W-1:0] rsp_data;

  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pe_status_reporter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .ce_n(ce_n), .oe_n(oe_n), .out_en(out_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    rd_req_valid = 1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rsp_data;
    rd_req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 cmd_ready", cmd_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    do_read(6'd5, d); check("R1 erased byte", d, 8'hFF);

    // R11 output enable
    ce_n = 0; oe_n = 0; #1 check("R11 both low", out_en, 1);
    ce_n = 1; #1 check("R11 ce high", out_en, 0);
    ce_n = 0; oe_n = 1; #1 check("R11 oe high", out_en, 0);
    @(negedge clk);

    // R4 R9 table of programs
    for (int i = 0; i < NVEC; i++) begin
      do_cmd(1'b0, VEC[i][23:16+ADDR_W-6], VEC[i][15:8]);
      wait_idle();
      do_read(VEC[i][21:16], d);
      check("R4 R9 program result", d, VEC[i][7:0]);
    end

    // R3 program busy length
    do_cmd(1'b0, 6'd10, 8'h00);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R3 program length", cnt, PROG_CYCLES);

    // R3 erase length, R5 erase result
    do_cmd(1'b1, 6'd0, 8'h00);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R3 erase length", cnt, ERASE_CYCLES);
    do_read(6'd1, d);  check("R5 erased addr1", d, 8'hFF);
    do_read(6'd10, d); check("R5 erased addr10", d, 8'hFF);

    // R6 R8 polling during program
    do_cmd(1'b0, 6'd3, 8'h5A);
    do_read(6'd3, d);  check("R6 R8 poll first", d, 8'h80);
    do_read(6'd20, d); check("R6 R8 poll second", d, 8'hC0);
    do_read(6'd3, d);  check("R6 R8 poll third", d, 8'h80);
    wait_idle();
    do_read(6'd3, d);  check("R9 true data after", d, 8'h5A);
    do_cmd(1'b0, 6'd3, 8'hC3);
    do_read(6'd3, d);  check("R8 toggle restarts", d, 8'h00);
    do_read(6'd3, d);  check("R6 R8 second msb1", d, 8'h40);
    wait_idle();
    do_read(6'd3, d);  check("R4 and-merge", d, 8'h42);

    // R7 polling during erase
    do_cmd(1'b1, 6'd0, 8'h00);
    do_read(6'd3, d);  check("R7 erase poll first", d, 8'h00);
    do_read(6'd3, d);  check("R7 erase poll second", d, 8'h40);
    wait_idle();
    do_read(6'd3, d);  check("R5 erased after poll", d, 8'hFF);

    // R9 read on the completion edge still returns status
    do_cmd(1'b0, 6'd7, 8'h0F);
    repeat (PROG_CYCLES - 1) @(negedge clk);
    do_read(6'd7, d);  check("R9 completion edge status", d, 8'h80);
    check("R9 busy dropped", busy, 0);
    do_read(6'd7, d);  check("R9 data after completion", d, 8'h0F);

    // R2 command offered while busy is ignored
    do_cmd(1'b0, 6'd12, 8'hF0);
    cmd_valid = 1; cmd_op = 0; cmd_addr = 6'd12; cmd_data = 8'h00;
    #1 check("R2 not ready while busy", cmd_ready, 0);
    repeat (2) @(negedge clk);
    cmd_valid = 0;
    wait_idle();
    @(negedge clk);
    check("R2 no extra operation", busy, 0);
    do_read(6'd12, d); check("R2 ignored command", d, 8'hF0);

    // R10 back-pressure
    rsp_ready = 0;
    rd_req_valid = 1; rd_addr = 6'd12;
    @(posedge clk); @(negedge clk);
    rd_req_valid = 0;
    check("R10 rsp_valid", rsp_valid, 1);
    check("R10 not ready when full", rd_req_ready, 0);
    repeat (3) @(negedge clk);
    check("R10 held valid", rsp_valid, 1);
    check("R10 held data", rsp_data, 8'hF0);
    rsp_ready = 1;
    #1 check("R10 ready when draining", rd_req_ready, 1);
    @(posedge clk); @(negedge clk);
    check("R10 drained", rsp_valid, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule